// File: doc/BRIEF.md
# Quad-Lane Serial Flash Indirect Read Controller

This block is a bus master for a serial flash-style device with up to four bidirectional data lines. Software sets up one transfer through a small register port: a configuration word that picks the command byte, the lane count of each phase, the address width and the number of idle turnaround clocks, plus a byte count and a start address. The block then drives chip-select and the serial clock and walks through the instruction, address, dummy and data phases in that order. Phases that are turned off are skipped.

There is no start command. The transfer launches by itself on the write that completes its setup. That write is the address write when the address phase is enabled, or the configuration write when it is not. Received bytes go into a receive queue, and software drains it through a data register. A status register shows whether a transfer is in flight, whether the queue has reached a programmable fill level, and whether a transfer has finished. When the queue is full, the serial clock pauses so that no byte is lost.

Top module: `qspi_indirect_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0, and every status field reads 0.
- R2: The address write at offset 5 launches a transfer when the address phase is on. The configuration write at offset 4 launches it when the address phase is off. No other write launches a transfer. Status bit 0 (busy) reads 1 from the cycle after the launching write until chip-select is released.
- R3: Chip-select goes low before the first rising sck edge and returns high after the last falling edge. The enabled phases run in this order: instruction, address, dummy, data. The total count of rising sck edges equals the sum of the clocks of all phases.
- R4: Configuration bits [7:0] hold the command byte. Bits [9:8] set the instruction lanes, [11:10] the address lanes and [21:20] the data lanes. The lane encoding is 0 = phase off, 1 = one lane (send on io[0], receive on io[1]), 2 = two lanes io[1:0], 3 = four lanes io[3:0]. Bits go out most significant first, and the highest lane index carries the most significant bit of each group.
- R5: Configuration bits [13:12] select an address width of 8, 16, 24 or 32 bits for codes 0 to 3. Only the low bits of the written address, up to that width, are sent.
- R6: Configuration bits [18:14] give the number of dummy clocks between the address and data phases. During those clocks io_oe is 0.
- R7: The length register at offset 3 holds the byte count minus one. A read with data lanes on returns exactly that count plus one bytes.
- R8: Reads of the data register at offset 6 return received bytes in arrival order and remove one byte each. Status bit 1 reads 1 when the queue level is at least the control field at offset 0, bits [3:0], plus one.
- R9: When the receive queue is full at the start of a byte, sck stops with busy held high and cs_n low. Clocking resumes after a byte is drained, and no byte is lost.
- R10: Status bit 2 (done) sets when a transfer ends. Writing a 1 to bit 2 of offset 2 clears it. Writing a 0 leaves it set.
- R11: Writes to offsets 3, 4 and 5 while busy are ignored. The running transfer is unchanged and no new transfer follows it.
- R12: Clock mode 0 applies: sck idles low, the device's data is sampled on the rising edge, and io_out changes only while sck is low.
- R13: Register offsets are 0 control, 1 status (bits [15:8] hold the queue level), 2 flag clear, 3 length, 4 configuration, 5 address and 6 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the data register) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| sck | output | 1 | Serial clock, half the system clock rate |
| cs_n | output | 1 | Chip-select, active low |
| io_out | output | 4 | Serial data driven to the device |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Serial data from the device |

## Verification
The bench models the device as an edge-counting responder. It records what is driven on every rising sck edge and supplies read data computed from a per-transfer salt, so the command, the address bits, the turnaround gap and the byte order can each be rebuilt and compared against independently computed values. Random mixes of per-phase lane counts, address widths, dummy counts and lengths show whether lane mapping and phase skipping stay correct across combinations. Directed cases then separate the remaining behaviours: launching with and without an address phase, a long read that fills the queue and must stall rather than drop bytes, threshold edges, ignored writes while busy, and flag-clear writes of zero and one.

// File: rtl/qspi_pkg.sv
// Shared types and helpers for the quad-lane indirect read controller.
// Assumes lane codes: 0 off, 1 one lane, 2 two lanes, 3 four lanes.
package qspi_pkg;

    localparam int DUMMY_W = 5;

    localparam logic [2:0] OFF_CTRL   = 3'd0;
    localparam logic [2:0] OFF_STATUS = 3'd1;
    localparam logic [2:0] OFF_FCLR   = 3'd2;
    localparam logic [2:0] OFF_DLEN   = 3'd3;
    localparam logic [2:0] OFF_CFG    = 3'd4;
    localparam logic [2:0] OFF_ADDR   = 3'd5;
    localparam logic [2:0] OFF_DATA   = 3'd6;

    typedef enum logic [1:0] {
        LN_NONE = 2'd0,
        LN_ONE  = 2'd1,
        LN_TWO  = 2'd2,
        LN_FOUR = 2'd3
    } lane_mode_e;

    // Order matters: the sequencer compares states to pick the next phase.
    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_CS_SETUP = 3'd1,
        SQ_INSTR    = 3'd2,
        SQ_ADDR     = 3'd3,
        SQ_DUMMY    = 3'd4,
        SQ_DATA     = 3'd5,
        SQ_CS_HOLD  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic [7:0]         instr;
        lane_mode_e         imode;
        lane_mode_e         amode;
        logic [1:0]         asize;
        logic [DUMMY_W-1:0] dummy;
        lane_mode_e         dmode;
    } xfer_cfg_t;

    // log2 of the lane count; an off phase never shifts.
    function automatic logic [1:0] lane_shift(lane_mode_e m);
        case (m)
            LN_TWO:  return 2'd1;
            LN_FOUR: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] lane_count(lane_mode_e m);
        case (m)
            LN_ONE:  return 3'd1;
            LN_TWO:  return 3'd2;
            LN_FOUR: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [5:0] addr_bits(logic [1:0] sz);
        return 6'(({4'd0, sz} + 6'd1) << 3);
    endfunction

endpackage

// File: rtl/qspi_rx_fifo.sv
// Receive queue between the serial sequencer and the register port.
// Assumes DEPTH is a power of two; the pointers wrap naturally.
module qspi_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);
    assign rdata = mem[rptr];

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8

endmodule

// File: rtl/qspi_regs.sv
// Register port: holds setup, launches on the completing write, exposes
// status flags and the data pop. Assumes single-cycle read strobes.
module qspi_regs
    import qspi_pkg::*;
#(
    parameter int DLEN_W = 16,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              seq_busy,
    input  logic              seq_done,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [7:0]        fifo_rdata,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic              start,
    output xfer_cfg_t         cfg,
    output logic [DLEN_W-1:0] dlen,
    output logic [31:0]       addr
);

    logic [3:0] thresh_q;
    logic       start_q, done_q;
    logic       busy_all, wr_ok, thr_flag, launch;
    xfer_cfg_t  cfg_new;

    assign busy_all = seq_busy | start_q;
    assign wr_ok    = reg_we && !busy_all;
    assign start    = start_q;
    assign fifo_pop = reg_re && (reg_addr == OFF_DATA) && !fifo_empty;
    assign thr_flag = (32'(fifo_level) >= (32'(thresh_q) + 32'd1));

    // Decode of a configuration write into its fields.
    always_comb begin
        cfg_new.instr = reg_wdata[7:0];
        cfg_new.imode = lane_mode_e'(reg_wdata[9:8]);
        cfg_new.amode = lane_mode_e'(reg_wdata[11:10]);
        cfg_new.asize = reg_wdata[13:12];
        cfg_new.dummy = reg_wdata[18:14];
        cfg_new.dmode = lane_mode_e'(reg_wdata[21:20]);
    end

    // Launch when the last required register of the setup is written.
    always_comb begin
        launch = 1'b0;
        if (wr_ok && reg_addr == OFF_ADDR && cfg.amode != LN_NONE) launch = 1'b1;
        if (wr_ok && reg_addr == OFF_CFG && cfg_new.amode == LN_NONE) launch = 1'b1;
    end

    // Setup registers, launch pulse and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_q <= '0;
            cfg      <= '0;
            dlen     <= '0;
            addr     <= '0;
            start_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            start_q <= launch;
            if (reg_we && reg_addr == OFF_CTRL) thresh_q <= reg_wdata[3:0];
            if (wr_ok && reg_addr == OFF_CFG)   cfg      <= cfg_new;
            if (wr_ok && reg_addr == OFF_DLEN)  dlen     <= reg_wdata[DLEN_W-1:0];
            if (wr_ok && reg_addr == OFF_ADDR)  addr     <= reg_wdata;
            if (seq_done)
                done_q <= 1'b1;
            else if (reg_we && reg_addr == OFF_FCLR && reg_wdata[2])
                done_q <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL:   reg_rdata = {28'd0, thresh_q};
            OFF_STATUS: reg_rdata = {16'd0, 8'(fifo_level), 5'd0, done_q, thr_flag, busy_all};
            OFF_DLEN:   reg_rdata = 32'(dlen);
            OFF_CFG:    reg_rdata = {10'd0, cfg.dmode, 1'b0, cfg.dummy, cfg.asize,
                                     cfg.amode, cfg.imode, cfg.instr};
            OFF_ADDR:   reg_rdata = addr;
            OFF_DATA:   reg_rdata = fifo_empty ? 32'd0 : {24'd0, fifo_rdata};
            default:    reg_rdata = '0;
        endcase
    end

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !seq_busy); // R11
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_busy) |-> done_q); // R10

endmodule

// File: rtl/qspi_seq.sv
// Phase sequencer: chip-select, mode-0 serial clock at clk/2, per-phase
// lane mapping and receive shifting. Assumes cfg/addr/dlen are stable
// while start is high; they are latched at launch.
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int DLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_cfg_t         cfg,
    input  logic [DLEN_W-1:0] dlen,
    input  logic [31:0]       addr,
    input  logic              fifo_full,
    output logic              push,
    output logic [7:0]        push_data,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    seq_state_e        state, follow;
    xfer_cfg_t         cfg_q;
    logic [31:0]       addr_q, sh, follow_sh;
    logic [DLEN_W-1:0] dlen_q, bytes_left;
    logic [5:0]        clk_left, follow_clks, abits;
    logic [3:0]        byte_clk, cpb;
    logic [7:0]        rx_sh, rx_next;
    logic              sck_q, cs_n_q, stall;
    lane_mode_e        out_mode;

    assign abits = addr_bits(cfg_q.asize);
    assign cpb   = 4'(4'd8 >> lane_shift(cfg_q.dmode));
    assign busy  = (state != SQ_IDLE);
    assign done  = (state == SQ_CS_HOLD);
    assign sck   = sck_q;
    assign cs_n  = cs_n_q;
    assign stall = (state == SQ_DATA) && !sck_q && (byte_clk == cpb) && fifo_full;
    assign push  = (state == SQ_DATA) && !sck_q && !stall && (byte_clk == 4'd1);
    assign push_data = rx_next;

    // Next enabled phase after the current state, with its load values.
    always_comb begin
        follow = SQ_CS_HOLD;
        if (cfg_q.dmode != LN_NONE && state < SQ_DATA)  follow = SQ_DATA;
        if (cfg_q.dummy != '0      && state < SQ_DUMMY) follow = SQ_DUMMY;
        if (cfg_q.amode != LN_NONE && state < SQ_ADDR)  follow = SQ_ADDR;
        if (cfg_q.imode != LN_NONE && state < SQ_INSTR) follow = SQ_INSTR;
        case (follow)
            SQ_INSTR: begin
                follow_clks = 6'(6'd8 >> lane_shift(cfg_q.imode));
                follow_sh   = {cfg_q.instr, 24'd0};
            end
            SQ_ADDR: begin
                follow_clks = 6'(abits >> lane_shift(cfg_q.amode));
                follow_sh   = addr_q << (6'd32 - abits);
            end
            SQ_DUMMY: begin
                follow_clks = 6'(cfg_q.dummy);
                follow_sh   = '0;
            end
            default: begin
                follow_clks = '0;
                follow_sh   = '0;
            end
        endcase
    end

    // Receive shift: gather the lanes of the data phase, MSB first.
    always_comb begin
        case (cfg_q.dmode)
            LN_TWO:  rx_next = {rx_sh[5:0], io_in[1:0]};
            LN_FOUR: rx_next = {rx_sh[3:0], io_in[3:0]};
            default: rx_next = {rx_sh[6:0], io_in[1]};
        endcase
    end

    // Output lane mapping for the transmitting phases.
    always_comb begin
        out_mode = LN_NONE;
        if (state == SQ_INSTR) out_mode = cfg_q.imode;
        if (state == SQ_ADDR)  out_mode = cfg_q.amode;
        case (out_mode)
            LN_ONE:  begin io_out = {3'd0, sh[31]};    io_oe = 4'b0001; end
            LN_TWO:  begin io_out = {2'd0, sh[31:30]}; io_oe = 4'b0011; end
            LN_FOUR: begin io_out = sh[31:28];         io_oe = 4'b1111; end
            default: begin io_out = 4'd0;              io_oe = 4'b0000; end
        endcase
    end

    // Phase state machine with the clock, counters and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            cfg_q      <= '0;
            addr_q     <= '0;
            dlen_q     <= '0;
            sh         <= '0;
            clk_left   <= '0;
            byte_clk   <= '0;
            bytes_left <= '0;
            rx_sh      <= '0;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        cfg_q  <= cfg;
                        addr_q <= addr;
                        dlen_q <= dlen;
                        cs_n_q <= 1'b0;
                        state  <= SQ_CS_SETUP;
                    end
                end
                SQ_CS_SETUP: begin
                    state      <= follow;
                    clk_left   <= follow_clks;
                    sh         <= follow_sh;
                    byte_clk   <= cpb;
                    bytes_left <= dlen_q;
                end
                SQ_INSTR, SQ_ADDR, SQ_DUMMY: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q <= 1'b0;
                        if (clk_left == 6'd1) begin
                            state      <= follow;
                            clk_left   <= follow_clks;
                            sh         <= follow_sh;
                            byte_clk   <= cpb;
                            bytes_left <= dlen_q;
                        end else begin
                            clk_left <= clk_left - 1'b1;
                            sh       <= sh << lane_count(out_mode);
                        end
                    end
                end
                SQ_DATA: begin
                    if (!sck_q) begin
                        if (!stall) begin
                            sck_q <= 1'b1;
                            rx_sh <= rx_next;
                        end
                    end else begin
                        sck_q <= 1'b0;
                        if (byte_clk == 4'd1) begin
                            if (bytes_left == '0) begin
                                state <= SQ_CS_HOLD;
                            end else begin
                                bytes_left <= bytes_left - 1'b1;
                                byte_clk   <= cpb;
                            end
                        end else begin
                            byte_clk <= byte_clk - 1'b1;
                        end
                    end
                end
                SQ_CS_HOLD: begin
                    cs_n_q <= 1'b1;
                    state  <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> !cs_n_q); // R3
    AST_IO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> $stable(io_out)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> (!sck_q && io_oe == 4'b0000)); // R1
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !push) |=> !sck_q); // R9

endmodule

// File: rtl/qspi_indirect_ctrl.sv
// Top: register port, phase sequencer and receive queue of the quad-lane
// indirect read controller. Assumes FIFO_DEPTH is a power of two.
module qspi_indirect_ctrl
    import qspi_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DLEN_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    xfer_cfg_t         cfg;
    logic [DLEN_W-1:0] dlen;
    logic [31:0]       addr;
    logic              start, seq_busy, seq_done;
    logic              push, pop, full, empty;
    logic [7:0]        push_data, fifo_rdata;
    logic [LVL_W-1:0]  level;

    qspi_regs #(.DLEN_W(DLEN_W), .LVL_W(LVL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .seq_busy   (seq_busy),
        .seq_done   (seq_done),
        .fifo_level (level),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (empty),
        .fifo_pop   (pop),
        .start      (start),
        .cfg        (cfg),
        .dlen       (dlen),
        .addr       (addr)
    );

    qspi_seq #(.DLEN_W(DLEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg       (cfg),
        .dlen      (dlen),
        .addr      (addr),
        .fifo_full (full),
        .push      (push),
        .push_data (push_data),
        .busy      (seq_busy),
        .done      (seq_done),
        .sck       (sck),
        .cs_n      (cs_n),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .io_in     (io_in)
    );

    qspi_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .rdata     (fifo_rdata),
        .level     (level),
        .full      (full),
        .empty     (empty)
    );

endmodule

// File: tb/tb_qspi_indirect_ctrl.sv
module tb_qspi_indirect_ctrl;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, cs_n;
    logic [3:0]  io_out, io_oe, io_in;

    int n_tests = 0, n_fail = 0, cyc = 0;

    // Responder model state.
    int       edge_cnt = 0, cs_falls = 0;
    logic [3:0] cap [512];
    logic [3:0] capoe [512];
    int       pre_clks = 0, dlanes = 0, cpb = 8;
    int       salt = 0;

    // Expected setup of the current transfer.
    int e_im, e_am, e_asz, e_dum, e_dm, e_dl;
    logic [7:0]  e_ins;
    logic [31:0] e_adr;

    qspi_indirect_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Edge recorder: sck rises only while cs_n is low.
    always @(posedge sck or negedge cs_n) begin
        if (sck) begin
            if (edge_cnt < 512) begin
                cap[edge_cnt]   <= io_out;
                capoe[edge_cnt] <= io_oe;
            end
            edge_cnt <= edge_cnt + 1;
        end else begin
            edge_cnt <= 0;
            cs_falls <= cs_falls + 1;
        end
    end

    function automatic logic [7:0] dbyte(int bi, int s);
        return 8'((bi * 29 + s) ^ (bi >> 1));
    endfunction

    // Device data driven for the next rising edge.
    always_comb begin
        int j, bi, p, sh;
        logic [7:0] v, b;
        io_in = 4'd0;
        if (!cs_n && dlanes != 0 && edge_cnt >= pre_clks) begin
            j  = edge_cnt - pre_clks;
            bi = j / cpb;
            p  = j % cpb;
            v  = 8'((bi * 29 + salt) ^ (bi >> 1));
            sh = 8 - dlanes * (p + 1);
            b  = v >> sh;
            case (dlanes)
                1:       io_in[1]   = b[0];
                2:       io_in[1:0] = b[1:0];
                default: io_in      = b[3:0];
            endcase
        end
    end

    function automatic int lanes(int m);
        return (m == 1) ? 1 : (m == 2) ? 2 : (m == 3) ? 4 : 0;
    endfunction

    function automatic logic [3:0] lmask(int m);
        return (m == 1) ? 4'b0001 : (m == 2) ? 4'b0011 : (m == 3) ? 4'b1111 : 4'b0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 6000; i++) begin
            rd(3'd1, st);
            if (!st[0]) break;
        end
    endtask

    // Program the setup; the launching write is the last one.
    task automatic launch(input int im, am, asz, dum, dm, dl,
                          input logic [7:0] ins, input logic [31:0] adr);
        int ic, ac;
        e_im = im; e_am = am; e_asz = asz; e_dum = dum; e_dm = dm; e_dl = dl;
        e_ins = ins; e_adr = adr;
        ic = (im != 0) ? 8 / lanes(im) : 0;
        ac = (am != 0) ? ((asz + 1) * 8) / lanes(am) : 0;
        pre_clks = ic + ac + dum;
        dlanes   = lanes(dm);
        cpb      = (dm != 0) ? 8 / dlanes : 8;
        salt     = int'($urandom_range(0, 255));
        wr(3'd3, 32'(dl));
        wr(3'd4, 32'(ins) | (32'(im) << 8) | (32'(am) << 10) | (32'(asz) << 12)
                 | (32'(dum) << 14) | (32'(dm) << 20));
        if (am != 0) wr(3'd5, adr);
    endtask

    // Compare the recorded bus activity and the received bytes.
    task automatic verify(input int falls_before);
        int ic, ac, dc, abits, nb;
        logic [31:0] v, st, d, amask;
        ic = (e_im != 0) ? 8 / lanes(e_im) : 0;
        abits = (e_asz + 1) * 8;
        ac = (e_am != 0) ? abits / lanes(e_am) : 0;
        nb = (e_dm != 0) ? e_dl + 1 : 0;
        dc = (e_dm != 0) ? nb * 8 / lanes(e_dm) : 0;
        chk("R2 one launch", 32'(cs_falls), 32'(falls_before + 1));
        chk("R3 edge total", 32'(edge_cnt), 32'(ic + ac + e_dum + dc));
        if (e_im != 0) begin
            v = 0;
            for (int k = 0; k < ic; k++) v = (v << lanes(e_im)) | 32'(cap[k] & lmask(e_im));
            chk("R4 instruction", v, 32'(e_ins));
            chk("R4 instr lanes", 32'(capoe[0]), 32'(lmask(e_im)));
        end
        if (e_am != 0) begin
            v = 0;
            for (int k = ic; k < ic + ac; k++) v = (v << lanes(e_am)) | 32'(cap[k] & lmask(e_am));
            amask = (abits == 32) ? 32'hffff_ffff : ((32'd1 << abits) - 1);
            chk("R5 address", v, e_adr & amask);
            chk("R4 addr lanes", 32'(capoe[ic]), 32'(lmask(e_am)));
        end
        if (e_dum != 0) begin
            v = 0;
            for (int k = ic + ac; k < ic + ac + e_dum; k++) v = v | 32'(capoe[k]);
            chk("R6 dummy not driven", v, 32'd0);
        end
        rd(3'd1, st);
        chk("R10 done set", 32'(st[2]), 32'd1);
        chk("R7 level", 32'(st[15:8]), 32'(nb));
        for (int k = 0; k < nb; k++) begin
            rd(3'd6, d);
            chk("R12 data byte R8 order", d, 32'(dbyte(k, salt)));
        end
        wr(3'd2, 32'd4);
    endtask

    initial begin
        logic [31:0] st, d;
        int f0, got, ec;
        void'($urandom(32'h51A7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R13 reset state
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 io_oe", 32'(io_oe), 32'd0);
        rd(3'd1, st);
        chk("R1 R13 status", st, 32'd0);

        // R2: configuration write with address phase on does not launch.
        f0 = cs_falls;
        wr(3'd3, 32'd1);
        wr(3'd4, 32'h9B | (32'd3 << 8) | (32'd3 << 10) | (32'd2 << 12) | (32'd6 << 14) | (32'd3 << 20));
        repeat (10) @(negedge clk);
        rd(3'd1, st);
        chk("R2 no launch on cfg", {31'd0, st[0]}, 32'd0);
        chk("R2 cs idle", 32'(cs_falls), 32'(f0));
        e_im = 3; e_am = 3; e_asz = 2; e_dum = 6; e_dm = 3; e_dl = 1;
        e_ins = 8'h9B; e_adr = 32'h5612_3456;
        pre_clks = 2 + 6 + 6; dlanes = 4; cpb = 2; salt = 77;
        wr(3'd5, e_adr);
        rd(3'd1, st);
        chk("R2 busy after addr write", {31'd0, st[0]}, 32'd1);
        wait_idle();
        verify(f0);

        // R2: no address phase, configuration write launches.
        f0 = cs_falls;
        launch(1, 0, 0, 0, 1, 2, 8'h3C, 32'h0);
        wait_idle();
        verify(f0);

        // R5: 8-bit address keeps only low bits.
        f0 = cs_falls;
        launch(1, 1, 0, 0, 2, 0, 8'hA5, 32'hABCD_EF12);
        wait_idle();
        verify(f0);

        // Random mixes of lanes, widths, dummies and lengths.
        for (int t = 0; t < 30; t++) begin
            f0 = cs_falls;
            launch(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)), int'($urandom_range(0, 8)),
                   int'($urandom_range(0, 3)), int'($urandom_range(0, DEPTH - 1)),
                   8'($urandom), $urandom);
            wait_idle();
            verify(f0);
        end

        // R10: writing zero keeps done, writing bit 2 clears it.
        f0 = cs_falls;
        launch(1, 0, 0, 0, 0, 0, 8'h06, 32'h0);
        wait_idle();
        wr(3'd2, 32'd0);
        rd(3'd1, st);
        chk("R10 zero write keeps done", {31'd0, st[2]}, 32'd1);
        wr(3'd2, 32'd4);
        rd(3'd1, st);
        chk("R10 clear done", {31'd0, st[2]}, 32'd0);

        // R8: threshold field 2 means three bytes.
        wr(3'd0, 32'd2);
        f0 = cs_falls;
        launch(1, 3, 2, 2, 3, 3, 8'hEB, 32'h00A0_0010);
        wait_idle();
        rd(3'd1, st);
        chk("R8 threshold reached", {31'd0, st[1]}, 32'd1);
        rd(3'd6, d);
        chk("R8 first byte", d, 32'(dbyte(0, salt)));
        rd(3'd6, d);
        rd(3'd1, st);
        chk("R8 below threshold", {31'd0, st[1]}, 32'd0);
        rd(3'd6, d);
        rd(3'd6, d);
        chk("R8 last byte", d, 32'(dbyte(3, salt)));
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd4);

        // R9: long read fills the queue and must stall.
        f0 = cs_falls;
        launch(1, 3, 2, 4, 3, 19, 8'h6B, 32'h0012_3400);
        repeat (300) @(negedge clk);
        ec = edge_cnt;
        repeat (40) @(negedge clk);
        chk("R9 clock stopped", 32'(edge_cnt), 32'(ec));
        chk("R9 stall point", 32'(ec), 32'(pre_clks + DEPTH * cpb));
        chk("R9 cs held", 32'(cs_n), 32'd0);
        rd(3'd1, st);
        chk("R9 busy while stalled", {31'd0, st[0]}, 32'd1);
        got = 0;
        for (int i = 0; i < 2000 && got < 20; i++) begin
            rd(3'd1, st);
            if (st[15:8] != 0) begin
                rd(3'd6, d);
                chk("R9 drained byte", d, 32'(dbyte(got, salt)));
                got++;
            end
        end
        chk("R9 byte count", 32'(got), 32'd20);
        wait_idle();
        wr(3'd2, 32'd4);

        // R11: writes during a transfer are ignored.
        f0 = cs_falls;
        launch(1, 1, 1, 20, 1, 5, 8'h0B, 32'h0000_1234);
        repeat (30) @(negedge clk);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'hEE | (32'd1 << 8));
        wr(3'd5, 32'h0000_7777);
        wait_idle();
        verify(f0);
        repeat (30) @(negedge clk);
        chk("R11 no second launch", 32'(cs_falls), 32'(f0 + 1));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule